// File: doc/BRIEF.md
# Mailbox Receive Overrun Status Tracker

This block holds per-mailbox receive status for a message controller with sixteen receive mailboxes. Each time a received frame is stored into a mailbox, the block sees a one-cycle store pulse carrying that mailbox's index. The pulse marks the mailbox as holding a message that the host has not yet acknowledged.

If another frame lands in the same mailbox before the host acknowledges the first one, the first message is lost. The new frame takes its place, and the block raises a sticky overwrite flag for that mailbox. Software sees three 16-bit registers through a small host port:

- a pending register, cleared by writing 1 to a bit;
- an overwrite register, cleared by writing 1 to a bit;
- an interrupt mask register, written directly.

A single interrupt line reports any overwrite flag that is not masked. In every register view the two byte halves are exchanged relative to mailbox order.

Top module: `rx_overrun_tracker`

## Requirements
- R1: After reset, the pending flags, overwrite flags and mask bits are all 0, `irq` is 0 and `host_rdata` is 0.
- R2: A store pulse with an index from 0 to 15 sets that mailbox's pending flag. The flag is visible from the next clock edge.
- R3: A store pulse to a mailbox whose pending flag is already set (and is not being cleared in that cycle) sets the mailbox's overwrite flag. An overwrite flag never sets in any other way.
- R4: A write to address 0 clears each pending flag whose register bit is 1. Register bits written as 0 leave their flags unchanged.
- R5: A write to address 1 clears each overwrite flag whose register bit is 1. Register bits written as 0 leave their flags unchanged.
- R6: The register view maps the mailboxes as follows, for the pending, overwrite and mask registers alike:
  - mailbox m with m < 8 sits at register bit m+8;
  - mailbox m with m >= 8 sits at register bit m-8.
- R7: When a store to a mailbox and a pending clear of the same mailbox fall in the same cycle, the pending flag stays set and the overwrite flag does not set.
- R8: When a new overwrite of a mailbox coincides with a write-1 clear of its overwrite flag, the flag stays set.
- R9: Reads have one cycle of latency. `host_rdata` takes its new value at the clock edge that samples `host_rd` and holds it until the next read. Read addresses return:
  - 0: the pending register;
  - 1: the overwrite register;
  - 2: the mask register;
  - 3: zero.
- R10: `irq` is 1 exactly when some mailbox has its overwrite flag set and its mask bit 0. A mask bit of 1 keeps that mailbox's flag off the interrupt.
- R11: Store pulses whose index is 16 or above change no flag.
- R12: A write to address 2 loads the mask register with `host_wdata`. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_valid | input | 1 | One-cycle pulse: a received frame was stored |
| store_idx | input | 5 | Mailbox index of the stored frame |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select: 0 pending, 1 overwrite, 2 mask |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| irq | output | 1 | Combined unmasked overwrite interrupt |

## Verification
The hardest situations to reach from the ports are the two same-cycle collisions:

- a store that meets a pending-clear write to the same mailbox;
- an overwrite that meets a clear of its own overwrite flag.

Each needs the mailbox already pending, and for the second one already overwritten. The bench first builds that state with directed stores, then drives the store pulse and the host write in one cycle, using bit positions computed through the swapped mapping. A random phase then mixes stores to a few mailboxes, out-of-range indices and random writes so that such collisions recur. A behavioural reference model follows every clock throughout.

// File: rtl/rxov_pkg.sv
package rxov_pkg;
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_OVR  = 2'd1,
    REG_MASK = 2'd2,
    REG_NONE = 2'd3
  } rxov_reg_e;
endpackage

// File: rtl/rxov_store_decode.sv
module rxov_store_decode #(
  parameter int NUM_MBOX = 16,
  parameter int IDX_W    = 5
) (
  input  logic                store_valid,
  input  logic [IDX_W-1:0]    store_idx,
  output logic [NUM_MBOX-1:0] store_hit
);
  // One-hot decode; indices without a mailbox select nothing.
  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_dec
    assign store_hit[i] = store_valid && (store_idx == IDX_W'(i));
  end
endmodule

// File: rtl/rxov_flag_bank.sv
module rxov_flag_bank #(
  parameter int NUM_MBOX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MBOX-1:0] store_hit,
  input  logic [NUM_MBOX-1:0] pend_clr,
  input  logic [NUM_MBOX-1:0] ov_clr,
  output logic [NUM_MBOX-1:0] pend_q,
  output logic [NUM_MBOX-1:0] ov_q,
  output logic [NUM_MBOX-1:0] ovf_evt
);
  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbox
    // An acknowledgement in the same cycle means the old message was consumed.
    assign ovf_evt[i] = store_hit[i] && pend_q[i] && !pend_clr[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        ov_q[i]   <= 1'b0;
      end else begin
        pend_q[i] <= store_hit[i] || (pend_q[i] && !pend_clr[i]);
        ov_q[i]   <= ovf_evt[i]   || (ov_q[i]   && !ov_clr[i]);
      end
    end
  end
endmodule

// File: rtl/rxov_host_if.sv
module rxov_host_if
  import rxov_pkg::*;
#(
  parameter int NUM_MBOX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [1:0]          host_addr,
  input  logic [NUM_MBOX-1:0] host_wdata,
  input  logic [NUM_MBOX-1:0] pend_q,
  input  logic [NUM_MBOX-1:0] ov_q,
  output logic [NUM_MBOX-1:0] pend_clr,
  output logic [NUM_MBOX-1:0] ov_clr,
  output logic [NUM_MBOX-1:0] mask_q,
  output logic [NUM_MBOX-1:0] host_rdata
);
  localparam int HALF = NUM_MBOX / 2;

  // Exchange the two halves. Applying it twice is the identity,
  // so one function serves both directions.
  function automatic logic [NUM_MBOX-1:0] swap_halves(input logic [NUM_MBOX-1:0] v);
    logic [NUM_MBOX-1:0] r;
    for (int b = 0; b < NUM_MBOX; b++) begin
      r[b] = (b >= HALF) ? v[b-HALF] : v[b+HALF];
    end
    return r;
  endfunction

  rxov_reg_e           sel;
  logic [NUM_MBOX-1:0] wdata_mbox;
  logic [NUM_MBOX-1:0] rd_mux;

  assign sel        = rxov_reg_e'(host_addr);
  assign wdata_mbox = swap_halves(host_wdata);
  assign pend_clr   = (host_wr && sel == REG_PEND) ? wdata_mbox : '0;
  assign ov_clr     = (host_wr && sel == REG_OVR)  ? wdata_mbox : '0;

  always_comb begin
    unique case (sel)
      REG_PEND: rd_mux = swap_halves(pend_q);
      REG_OVR:  rd_mux = swap_halves(ov_q);
      REG_MASK: rd_mux = swap_halves(mask_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      host_rdata <= '0;
    end else begin
      if (host_wr && sel == REG_MASK) mask_q <= wdata_mbox;
      if (host_rd) host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rx_overrun_tracker.sv
module rx_overrun_tracker #(
  parameter int NUM_MBOX = 16,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                store_valid,
  input  logic [IDX_W-1:0]    store_idx,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [1:0]          host_addr,
  input  logic [NUM_MBOX-1:0] host_wdata,
  output logic [NUM_MBOX-1:0] host_rdata,
  output logic                irq
);
  logic [NUM_MBOX-1:0] store_hit;
  logic [NUM_MBOX-1:0] pend_clr;
  logic [NUM_MBOX-1:0] ov_clr;
  logic [NUM_MBOX-1:0] pend_q;
  logic [NUM_MBOX-1:0] ov_q;
  logic [NUM_MBOX-1:0] ovf_evt;
  logic [NUM_MBOX-1:0] mask_q;

  rxov_store_decode #(.NUM_MBOX(NUM_MBOX), .IDX_W(IDX_W)) u_dec (
    .store_valid (store_valid),
    .store_idx   (store_idx),
    .store_hit   (store_hit)
  );

  rxov_flag_bank #(.NUM_MBOX(NUM_MBOX)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_hit (store_hit),
    .pend_clr  (pend_clr),
    .ov_clr    (ov_clr),
    .pend_q    (pend_q),
    .ov_q      (ov_q),
    .ovf_evt   (ovf_evt)
  );

  rxov_host_if #(.NUM_MBOX(NUM_MBOX)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .pend_q     (pend_q),
    .ov_q       (ov_q),
    .pend_clr   (pend_clr),
    .ov_clr     (ov_clr),
    .mask_q     (mask_q),
    .host_rdata (host_rdata)
  );

  assign irq = |(ov_q & ~mask_q);
endmodule

// File: rtl/rxov_checker.sv
module rxov_checker #(
  parameter int NUM_MBOX = 16,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                store_valid,
  input logic [IDX_W-1:0]    store_idx,
  input logic                host_rd,
  input logic [1:0]          host_addr,
  input logic [NUM_MBOX-1:0] host_rdata,
  input logic                irq,
  input logic [NUM_MBOX-1:0] store_hit,
  input logic [NUM_MBOX-1:0] pend_clr,
  input logic [NUM_MBOX-1:0] ov_clr,
  input logic [NUM_MBOX-1:0] pend_q,
  input logic [NUM_MBOX-1:0] ov_q,
  input logic [NUM_MBOX-1:0] mask_q
);
  p_store_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|store_hit) |=> ((pend_q & $past(store_hit)) == $past(store_hit)));

  p_ov_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ov_q & ~$past(ov_q)) & ~($past(pend_q) & $past(store_hit) & ~$past(pend_clr))) == '0);

  p_pend_fall_by_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (~pend_q & $past(pend_q) & ~$past(pend_clr)) == '0);

  p_ov_fall_by_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (~ov_q & $past(ov_q) & ~$past(ov_clr)) == '0);

  p_store_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(store_hit & pend_clr)) |=>
      ((pend_q & $past(store_hit & pend_clr)) == $past(store_hit & pend_clr)));

  p_overwrite_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(store_hit & pend_q & ~pend_clr & ov_clr)) |=>
      ((ov_q & $past(store_hit & pend_q & ~pend_clr)) == $past(store_hit & pend_q & ~pend_clr)));

  p_unused_addr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd3) |=> (host_rdata == '0));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ov_q & ~mask_q) == '0) |-> !irq);

  p_oob_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && int'(store_idx) >= NUM_MBOX) |-> (store_hit == '0));

  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_hit));
endmodule

bind rx_overrun_tracker rxov_checker #(.NUM_MBOX(NUM_MBOX), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .store_valid (store_valid),
  .store_idx   (store_idx),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_rdata  (host_rdata),
  .irq         (irq),
  .store_hit   (store_hit),
  .pend_clr    (pend_clr),
  .ov_clr      (ov_clr),
  .pend_q      (pend_q),
  .ov_q        (ov_q),
  .mask_q      (mask_q)
);

// File: tb/rx_overrun_tracker_bench.sv
module rx_overrun_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        store_valid = 1'b0;
  logic [4:0]  store_idx = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_overrun_tracker u_rx_overrun_tracker (
    .clk(clk), .rst_n(rst_n), .store_valid(store_valid), .store_idx(store_idx),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  // Reference model: mailbox-ordered bit arrays.
  bit m_pend[16];
  bit m_ov[16];
  bit m_mask[16];
  logic [15:0] m_rdata;

  function automatic int reg_pos(int mbox);
    if (mbox < 8) return mbox + 8;
    return mbox - 8;
  endfunction

  function automatic logic [15:0] view(int which);
    logic [15:0] v = '0;
    for (int m = 0; m < 16; m++) begin
      if (which == 0) v[reg_pos(m)] = m_pend[m];
      if (which == 1) v[reg_pos(m)] = m_ov[m];
      if (which == 2) v[reg_pos(m)] = m_mask[m];
    end
    return v;
  endfunction

  function automatic bit model_irq();
    for (int m = 0; m < 16; m++) if (m_ov[m] && !m_mask[m]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < 16; m++) begin m_pend[m] = 0; m_ov[m] = 0; m_mask[m] = 0; end
      m_rdata = '0;
    end else begin
      if (host_rd) m_rdata = view(int'(host_addr));
      for (int m = 0; m < 16; m++) begin
        bit hit, pc, oc, nov;
        hit = store_valid && (int'(store_idx) == m);
        pc  = host_wr && host_addr == 2'd0 && host_wdata[reg_pos(m)];
        oc  = host_wr && host_addr == 2'd1 && host_wdata[reg_pos(m)];
        nov = hit && m_pend[m] && !pc;
        m_pend[m] = hit || (m_pend[m] && !pc);
        m_ov[m]   = nov || (m_ov[m] && !oc);
        if (host_wr && host_addr == 2'd2) m_mask[m] = host_wdata[reg_pos(m)];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model comparison on every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(irq == model_irq(), "R10 irq vs model", 16'(irq), 16'(model_irq()));
      check(host_rdata == m_rdata, "R9 rdata vs model", host_rdata, m_rdata);
    end
  end

  task automatic cyc(input bit sv, input int idx, input bit wr, input int addr,
                     input logic [15:0] wd, input bit rd);
    store_valid = sv; store_idx = 5'(idx);
    host_wr = wr; host_addr = 2'(addr); host_wdata = wd; host_rd = rd;
    @(negedge clk);
    store_valid = 0; host_wr = 0; host_rd = 0;
  endtask

  task automatic store(input int idx);
    cyc(1, idx, 0, 0, '0, 0);
  endtask

  task automatic wr(input int addr, input logic [15:0] wd);
    cyc(0, 0, 1, addr, wd, 0);
  endtask

  task automatic rd_expect(input int addr, input logic [15:0] exp, input string tag);
    cyc(0, 0, 0, addr, '0, 1);
    check(host_rdata === exp, tag, host_rdata, exp);
  endtask

  function automatic logic [15:0] bitm(int mbox);
    return 16'(1) << reg_pos(mbox);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(irq == 0 && host_rdata == 0, "R1 reset outputs", {host_rdata[14:0], irq}, '0);
    rd_expect(0, '0, "R1 pending after reset");
    rd_expect(1, '0, "R1 overwrite after reset");
    rd_expect(2, '0, "R1 mask after reset");

    store(3);
    rd_expect(0, 16'h0800, "R2 R6 pending mailbox 3 at bit 11");
    store(12);
    rd_expect(0, 16'h0810, "R2 R6 pending mailbox 12 at bit 4");
    store(3);
    rd_expect(1, 16'h0800, "R3 overwrite mailbox 3");
    check(irq == 1, "R10 irq on overwrite", 16'(irq), 16'd1);

    wr(0, 16'h0000);
    rd_expect(0, 16'h0810, "R4 write 0 keeps pending");
    wr(0, 16'h0800);
    rd_expect(0, 16'h0010, "R4 write 1 clears pending");
    store(3);
    rd_expect(1, 16'h0800, "R3 no new overwrite after ack");
    wr(1, 16'h0000);
    rd_expect(1, 16'h0800, "R5 write 0 keeps overwrite");
    wr(1, 16'h0800);
    rd_expect(1, 16'h0000, "R5 write 1 clears overwrite");
    check(irq == 0, "R10 irq low after clear", 16'(irq), 16'd0);

    wr(2, bitm(12));
    rd_expect(2, 16'h0010, "R12 R6 mask mailbox 12");
    store(12);
    rd_expect(1, 16'h0010, "R3 overwrite mailbox 12");
    check(irq == 0, "R10 masked overwrite gives no irq", 16'(irq), 16'd0);
    wr(3, 16'hFFFF);
    rd_expect(2, 16'h0010, "R12 address 3 write ignored");
    rd_expect(3, 16'h0000, "R9 address 3 reads zero");

    store(5);
    cyc(1, 5, 1, 0, bitm(5), 0);
    rd_expect(0, 16'h2810, "R7 store wins over pending clear");
    rd_expect(1, 16'h0010, "R7 no overwrite on acked store");

    store(5);
    rd_expect(1, 16'h2010, "R3 overwrite mailbox 5");
    cyc(1, 5, 1, 1, bitm(5), 0);
    rd_expect(1, 16'h2010, "R8 overwrite beats its clear");

    store(16);
    store(31);
    rd_expect(0, 16'h2810, "R11 out-of-range stores ignored");
    rd_expect(1, 16'h2010, "R11 overwrite unchanged");

    // R9 latency: rdata holds until the edge that samples the read.
    host_rd = 1; host_addr = 2'd2;
    #1 check(host_rdata == 16'h2010, "R9 rdata before edge", host_rdata, 16'h2010);
    @(negedge clk); host_rd = 0;
    check(host_rdata == 16'h0010, "R9 rdata after edge", host_rdata, 16'h0010);

    // Random mix, compared against the model every cycle.
    for (int n = 0; n < 2000; n++) begin
      int kind = $urandom_range(0, 9);
      int idx = (kind == 0) ? $urandom_range(16, 31) : $urandom_range(0, 3) * 5;
      cyc($urandom_range(0, 1), idx, kind < 5, $urandom_range(0, 3),
          16'($urandom), $urandom_range(0, 1));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule